// File: doc/BRIEF.md
# Mesh Route Computation Unit

This block decides where a head flit goes next inside one router of a two-dimensional mesh. It works in two steps. First it compares the router's own coordinates with the destination coordinates. From that comparison it builds a four-bit productive vector, which marks every compass port that brings the packet closer. Second, a selection policy picks exactly one output from that vector, or from the local ejection port, or, under congestion, from the ports that lead away from the destination.

Four policies are available, chosen per packet:
- dimension-ordered (all x hops before any y hop);
- oblivious, with a pseudo-random rotating scan that ignores network state;
- minimal adaptive, which takes the productive port with the shortest output queue;
- fully adaptive, which may misroute to a port inside the mesh when every productive queue is congested.

The header carries a misroute count. A detour is only allowed while that count is below a fixed ceiling, which bounds livelock. The decision and the updated count are registered, and appear one clock after the request.

Top module: `mesh_route_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rt_valid` is 0, `rt_port` is 0 and `rt_mr` is 0.
- R2: The clock edge that samples `hd_valid`=1 raises `rt_valid` and presents a result with exactly one bit of `rt_port` set. Bit encoding: bit0 east (+x), bit1 west (-x), bit2 north (+y), bit3 south (-y), bit4 local. A request with `hd_valid`=0 leaves `rt_valid` at 0 on the next cycle.
- R3: When the destination equals the current node, the local bit is chosen under every policy and `rt_mr` equals `hd_mr`.
- R4: Policy 0 (dimension order): east when the destination x is larger, west when it is smaller, and only when the x coordinates match, north or south by the sign of the y difference.
- R5: Policy 1 (oblivious): the chosen port is always one of the productive ports. Across repeated requests that have two productive ports, both ports occur.
- R6: Policy 2 (minimal adaptive): the chosen port is the productive port with the smallest queue length; ties go to the first in the order east, west, north, south.
- R7: Policy 3 (fully adaptive) misroutes when three conditions all hold: every productive queue exceeds QTHRESH, `hd_mr` is below MR_LIMIT, and some unproductive neighbour lies inside the mesh. It then picks the unproductive in-mesh port with the smallest queue (same tie order) and outputs `rt_mr` = `hd_mr`+1.
- R8: Policy 3 in all other cases picks as in R6 and keeps `rt_mr` = `hd_mr`; with `hd_mr` at MR_LIMIT only productive ports are chosen.
- R9: A misroute never selects a port that leaves the mesh: west is excluded at x=0, east at x=MESH_X-1, south at y=0 and north at y=MESH_Y-1.
- R10: Policies 0, 1 and 2 output `rt_mr` = `hd_mr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hd_valid | input | 1 | A head flit requests a route this cycle |
| here_x | input | COORD_W | Current node x coordinate |
| here_y | input | COORD_W | Current node y coordinate |
| dest_x | input | COORD_W | Destination x coordinate |
| dest_y | input | COORD_W | Destination y coordinate |
| q_len | input | 4*QLEN_W | Output queue occupancies, slice i belongs to port bit i (E, W, N, S) |
| hd_mr | input | MR_W | Misroute count from the header |
| policy | input | 2 | 0 dimension order, 1 oblivious, 2 minimal adaptive, 3 fully adaptive |
| rt_valid | output | 1 | Route result valid |
| rt_port | output | 5 | One-hot chosen port |
| rt_mr | output | MR_W | Updated misroute count |

## Verification
The bench targets these corner cases:
- The destination node itself. A design that skips the local check would forward the packet into a neighbour.
- Equal queue lengths. A wrong tie order would pick north or south where east should win.
- Misroute requests at the count ceiling. A missing cap would keep detouring and increment the count past its limit.
- Nodes at mesh corners, where every unproductive neighbour lies outside the mesh. A design that ignored the mesh edge would send the flit off the array.
- Oblivious mode toward a diagonal destination. A broken scan would keep returning the same port, or a non-productive one.

// File: rtl/rc_pkg.sv
// Shared constants for the route computation unit: port bit positions
// and policy codes. Assumes four compass ports plus one local port.
package rc_pkg;
    localparam int P_E = 0;
    localparam int P_W = 1;
    localparam int P_N = 2;
    localparam int P_S = 3;
    localparam int P_L = 4;
    localparam int NDIR = 4;

    typedef enum logic [1:0] {
        POL_DOR  = 2'd0,
        POL_OBL  = 2'd1,
        POL_MIN  = 2'd2,
        POL_FULL = 2'd3
    } policy_e;
endpackage

// File: rtl/rc_pdv.sv
// Productive direction stage: compares current and destination
// coordinates. It flags the ports that move closer, the ports that
// lead to an existing neighbour, and arrival. Assumes unsigned
// coordinates below the mesh size.
module rc_pdv #(
    parameter int COORD_W = 2,
    parameter int MESH_X  = 4,
    parameter int MESH_Y  = 4
) (
    input  logic [COORD_W-1:0] cx,
    input  logic [COORD_W-1:0] cy,
    input  logic [COORD_W-1:0] dx,
    input  logic [COORD_W-1:0] dy,
    output logic [3:0]         prod,
    output logic [3:0]         nbr,
    output logic               arrived
);
    import rc_pkg::*;
    localparam logic [COORD_W-1:0] XMAX = COORD_W'(MESH_X - 1);
    localparam logic [COORD_W-1:0] YMAX = COORD_W'(MESH_Y - 1);

    // Sign of each axis offset gives the productive bits.
    always_comb begin
        prod        = '0;
        prod[P_E]   = dx > cx;
        prod[P_W]   = dx < cx;
        prod[P_N]   = dy > cy;
        prod[P_S]   = dy < cy;
        arrived     = (dx == cx) && (dy == cy);
    end

    // Neighbour exists unless the node sits on that mesh edge.
    always_comb begin
        nbr       = '0;
        nbr[P_E]  = cx < XMAX;
        nbr[P_W]  = cx != '0;
        nbr[P_N]  = cy < YMAX;
        nbr[P_S]  = cy != '0;
    end
endmodule

// File: rtl/rc_lfsr.sv
// Free-running 16-bit Fibonacci LFSR (taps 16,14,13,11) used as the
// start point of the oblivious scan. Assumes a non-zero seed.
module rc_lfsr #(
    parameter int          W    = 16,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    logic fb;

    // Feedback from the tap positions.
    always_comb fb = state[15] ^ state[13] ^ state[12] ^ state[10];

    // Shift every cycle, reload the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= W'(SEED);
        else        state <= {state[W-2:0], fb};
    end

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);  // R5
endmodule

// File: rtl/rc_min_pick.sv
// Picks, among the masked ports, the one with the smallest queue
// length. Ties go to the lower bit index (E, W, N, S). Assumes the
// caller checks `any` before using `pick`.
module rc_min_pick #(
    parameter int QLEN_W = 4,
    parameter int NP     = 4
) (
    input  logic [NP-1:0]        mask,
    input  logic [NP*QLEN_W-1:0] q,
    output logic [NP-1:0]        pick,
    output logic                 any
);
    logic [QLEN_W-1:0] best;

    // Linear scan with strict less-than keeps the earlier port on a tie.
    always_comb begin
        pick = '0;
        any  = 1'b0;
        best = '0;
        for (int i = 0; i < NP; i++) begin
            if (mask[i] && (!any || q[i*QLEN_W +: QLEN_W] < best)) begin
                pick    = '0;
                pick[i] = 1'b1;
                best    = q[i*QLEN_W +: QLEN_W];
                any     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mesh_route_unit.sv
// Route computation for one mesh router. It builds the productive
// vector, applies the per-packet policy and registers a one-hot
// port and the updated misroute count one cycle after hd_valid.
// Assumes coordinates lie inside MESH_X by MESH_Y.
module mesh_route_unit #(
    parameter int COORD_W  = 2,
    parameter int MESH_X   = 4,
    parameter int MESH_Y   = 4,
    parameter int QLEN_W   = 4,
    parameter int QTHRESH  = 8,
    parameter int MR_W     = 2,
    parameter int MR_LIMIT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hd_valid,
    input  logic [COORD_W-1:0]  here_x,
    input  logic [COORD_W-1:0]  here_y,
    input  logic [COORD_W-1:0]  dest_x,
    input  logic [COORD_W-1:0]  dest_y,
    input  logic [4*QLEN_W-1:0] q_len,
    input  logic [MR_W-1:0]     hd_mr,
    input  logic [1:0]          policy,
    output logic                rt_valid,
    output logic [4:0]          rt_port,
    output logic [MR_W-1:0]     rt_mr
);
    import rc_pkg::*;
    localparam int                SCAN_W = $clog2(NDIR);
    localparam logic [MR_W-1:0]   MR_CAP = MR_W'(MR_LIMIT);
    localparam logic [QLEN_W-1:0] QTH    = QLEN_W'(QTHRESH);

    logic [3:0]        prod, nbr, unprod;
    logic              arrived;
    logic [15:0]       lfsr;
    logic [3:0]        min_pick, mis_pick, obl_pick;
    logic              min_any, mis_any;
    logic              congested, misroute_ok;
    logic [4:0]        nxt_port;
    logic [MR_W-1:0]   nxt_mr;
    policy_e           pol;

    rc_pdv #(.COORD_W(COORD_W), .MESH_X(MESH_X), .MESH_Y(MESH_Y)) u_pdv (
        .cx(here_x), .cy(here_y), .dx(dest_x), .dy(dest_y),
        .prod(prod), .nbr(nbr), .arrived(arrived)
    );

    rc_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .state(lfsr));

    rc_min_pick #(.QLEN_W(QLEN_W), .NP(NDIR)) u_min (
        .mask(prod), .q(q_len), .pick(min_pick), .any(min_any)
    );

    rc_min_pick #(.QLEN_W(QLEN_W), .NP(NDIR)) u_mis (
        .mask(unprod), .q(q_len), .pick(mis_pick), .any(mis_any)
    );

    // Unproductive ports that still reach an existing neighbour.
    always_comb unprod = ~prod & nbr;

    // Rotating scan over the productive bits starting at the LFSR value.
    always_comb begin
        logic [SCAN_W-1:0] idx;
        logic              hit;
        obl_pick = '0;
        hit      = 1'b0;
        for (int k = 0; k < NDIR; k++) begin
            idx = lfsr[SCAN_W-1:0] + SCAN_W'(k);
            if (!hit && prod[idx]) begin
                obl_pick[idx] = 1'b1;
                hit           = 1'b1;
            end
        end
    end

    // Congestion: every productive queue is above the threshold.
    always_comb begin
        congested = 1'b1;
        for (int i = 0; i < NDIR; i++)
            if (prod[i] && q_len[i*QLEN_W +: QLEN_W] <= QTH) congested = 1'b0;
        misroute_ok = congested && (hd_mr < MR_CAP) && mis_any;
    end

    // Policy selection of the next port and misroute count.
    always_comb begin
        pol      = policy_e'(policy);
        nxt_port = '0;
        nxt_mr   = hd_mr;
        if (arrived) begin
            nxt_port[P_L] = 1'b1;
        end else begin
            case (pol)
                POL_DOR:  nxt_port[3:0] = (prod[P_E] | prod[P_W]) ? (prod & 4'b0011)
                                                                  : (prod & 4'b1100);
                POL_OBL:  nxt_port[3:0] = obl_pick;
                POL_MIN:  nxt_port[3:0] = min_pick;
                default: begin
                    if (misroute_ok) begin
                        nxt_port[3:0] = mis_pick;
                        nxt_mr        = hd_mr + 1'b1;
                    end else begin
                        nxt_port[3:0] = min_pick;
                    end
                end
            endcase
        end
    end

    // Result register: one cycle of latency per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_valid <= 1'b0;
            rt_port  <= '0;
            rt_mr    <= '0;
        end else begin
            rt_valid <= hd_valid;
            if (hd_valid) begin
                rt_port <= nxt_port;
                rt_mr   <= nxt_mr;
            end
        end
    end

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid |-> $countones(rt_port) == 1);  // R2
    AST_LOCAL_ON_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid |-> rt_port[P_L] == $past(arrived));  // R3
    AST_DOR_X_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && $past(policy) == 2'd0 && $past(here_x != dest_x))
            |-> (rt_port[P_E] | rt_port[P_W]));  // R4
    AST_MR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && rt_mr != $past(hd_mr))
            |-> (rt_mr == $past(hd_mr) + 1'b1 && $past(hd_mr) < MR_CAP
                 && $past(policy) == 2'd3));  // R7
    AST_PRODUCTIVE_UNLESS_MISROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && !rt_port[P_L] && rt_mr == $past(hd_mr))
            |-> (rt_port[3:0] & $past(prod)) != '0);  // R8
    AST_STAY_IN_MESH: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid |-> (rt_port[3:0] & ~$past(nbr)) == '0);  // R9
endmodule

// File: tb/test_mesh_route_unit.sv
// Self-checking bench: directed corners plus seeded random requests
// compared with a behavioural model of the requirements.
module test_mesh_route_unit;
    localparam int CW = 2, MX = 4, MY = 4, QW = 4, QTH = 8, MRW = 2, MRL = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            hd_valid;
    logic [CW-1:0]   here_x, here_y, dest_x, dest_y;
    logic [4*QW-1:0] q_len;
    logic [MRW-1:0]  hd_mr;
    logic [1:0]      policy;
    logic            rt_valid;
    logic [4:0]      rt_port;
    logic [MRW-1:0]  rt_mr;

    int n_chk = 0, n_fail = 0;
    int seen_e = 0, seen_n = 0;

    always #2ns clk = ~clk;

    mesh_route_unit #(.COORD_W(CW), .MESH_X(MX), .MESH_Y(MY), .QLEN_W(QW),
                      .QTHRESH(QTH), .MR_W(MRW), .MR_LIMIT(MRL)) i_mesh_route_unit (
        .clk(clk), .rst_n(rst_n), .hd_valid(hd_valid),
        .here_x(here_x), .here_y(here_y), .dest_x(dest_x), .dest_y(dest_y),
        .q_len(q_len), .hd_mr(hd_mr), .policy(policy),
        .rt_valid(rt_valid), .rt_port(rt_port), .rt_mr(rt_mr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] qmin(input logic [3:0] m, input logic [4*QW-1:0] q);
        logic [3:0] r = '0; logic f = 0; logic [QW-1:0] b = '0;
        for (int i = 0; i < 4; i++)
            if (m[i] && (!f || q[i*QW +: QW] < b)) begin
                r = '0; r[i] = 1; b = q[i*QW +: QW]; f = 1;
            end
        return r;
    endfunction

    // Model: returns {mr, port}.
    function automatic logic [MRW+4:0] model(input int cx, cy, dx, dy, pol,
                                              input logic [4*QW-1:0] q, input int mr);
        logic [3:0] pr, nb, un, pk; logic cong;
        logic [4:0] port = '0; int nmr = mr;
        pr = {dy < cy, dy > cy, dx < cx, dx > cx};
        nb = {cy > 0, cy < MY-1, cx > 0, cx < MX-1};
        un = ~pr & nb;
        if (cx == dx && cy == dy) port[4] = 1;
        else if (pol == 0) port[3:0] = (dx != cx) ? (pr & 4'b0011) : (pr & 4'b1100);
        else if (pol == 3) begin
            cong = 1;
            for (int i = 0; i < 4; i++) if (pr[i] && q[i*QW +: QW] <= QTH) cong = 0;
            if (cong && mr < MRL && un != 0) begin pk = qmin(un, q); nmr = mr + 1; end
            else pk = qmin(pr, q);
            port[3:0] = pk;
        end else port[3:0] = qmin(pr, q);
        return {MRW'(nmr), port};
    endfunction

    // Drive one request at the falling edge, check one cycle later.
    task automatic run(input int cx, cy, dx, dy, pol, input logic [4*QW-1:0] q,
                       input int mr, input string req);
        logic [MRW+4:0] e; logic [3:0] pr;
        here_x = CW'(cx); here_y = CW'(cy); dest_x = CW'(dx); dest_y = CW'(dy);
        policy = 2'(pol); q_len = q; hd_mr = MRW'(mr); hd_valid = 1;
        @(negedge clk);
        hd_valid = 0;
        e  = model(cx, cy, dx, dy, pol, q, mr);
        pr = {dy < cy, dy > cy, dx < cx, dx > cx};
        check(rt_valid == 1, "R2", rt_valid, 1);
        if (pol == 1 && !(cx == dx && cy == dy)) begin
            check($countones(rt_port) == 1 && (rt_port[3:0] & pr) != 0 && !rt_port[4],
                  "R5", rt_port, pr);
            if (rt_port[0]) seen_e++;
            if (rt_port[2]) seen_n++;
        end else
            check(rt_port == e[4:0], req, rt_port, e[4:0]);
        check(rt_mr == e[MRW+4:5], (pol == 3) ? "R7/R8 mr" : "R10", rt_mr, e[MRW+4:5]);
    endtask

    initial begin
        #(4ns * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; hd_valid = 0; here_x = 0; here_y = 0; dest_x = 0; dest_y = 0;
        q_len = 0; hd_mr = 0; policy = 0;
        repeat (3) @(negedge clk);
        check(rt_valid == 0 && rt_port == 0 && rt_mr == 0, "R1", {rt_valid, rt_port}, 0);
        rst_n = 1;
        @(negedge clk);
        check(rt_valid == 0 && rt_port == 0 && rt_mr == 0, "R1", {rt_valid, rt_port}, 0);
        // R3: arrival under every policy
        for (int p = 0; p < 4; p++) run(2, 1, 2, 1, p, 16'hFFFF, 1, "R3");
        // R4: x first, then y
        run(1, 1, 3, 3, 0, 16'h0000, 0, "R4");
        run(2, 3, 2, 0, 0, 16'h0000, 0, "R4");
        run(3, 0, 0, 2, 0, 16'h0000, 0, "R4");
        // R6: ties go east before north
        run(1, 1, 3, 3, 2, 16'h5555, 0, "R6");
        run(1, 1, 0, 0, 2, 16'h3344, 0, "R6");  // W=4,S=3 -> S
        // R7: congested misroute from interior node
        run(1, 1, 3, 3, 3, 16'h29F9, 0, "R7");  // E=9,N=9 congested -> W or S
        // R8: at limit stays productive
        run(1, 1, 3, 3, 3, 16'h29F9, 2, "R8");
        // R9: corner node has no in-mesh unproductive port
        run(0, 0, 3, 3, 3, 16'h0F0F, 0, "R9");
        // R2: idle request leaves valid low
        @(negedge clk);
        check(rt_valid == 0, "R2 idle", rt_valid, 0);
        // R5: diagonal oblivious coverage
        for (int i = 0; i < 64; i++) run(0, 0, 3, 3, 1, 16'h0000, 0, "R5");
        check(seen_e > 0 && seen_n > 0, "R5 coverage", seen_e, seen_n);
        // Random mix
        for (int i = 0; i < 3000; i++)
            run($urandom % MX, $urandom % MY, $urandom % MX, $urandom % MY,
                $urandom % 4, 16'($urandom), $urandom % 3, "R6/R7/R8 random");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule